// File: doc/BRIEF.md
# Multichannel Coding Handshake Sequencer

This block runs the request handshake of a time-shared speech codec that serves many channels. When a request strobe arrives while the block is idle, it latches one sample's worth of request: the direction (encode or decode), the channel number, the PCM type, the coding-standard select, the enhancement-bit count, the ADPCM word width and both data words. It then walks a fixed six-stage schedule. During each stage it drives a one-hot stage index, which tells the datapath and the per-channel state memory which step to run. The captured channel number and options stay on the outputs for the whole operation.

The transcoding arithmetic is not part of this block. A pass-through stub stands in for it and produces the result at the end of the sixth stage. When encoding, the stub forwards the five upper bits of the PCM sample to the ADPCM port. When decoding, it places the ADPCM word back into the PCM field. In both directions it respects the chosen word width.

The block has two states. SEQ_IDLE waits for a strobe. The transition ACCEPT (strobe high in SEQ_IDLE) captures the request and enters SEQ_RUN with stage 1 active. In SEQ_RUN the transition ADVANCE moves the one-hot stage up by one on each clock. The transition FINISH, taken on the edge that ends stage 6, writes the registered result, raises the status flag again and returns to SEQ_IDLE.

Top module: `chs_top`

## Requirements
- R1: After reset `busy` is 0, `enc_stat` and `dec_stat` are both 1, `stage_hot` is 0, and `pcm_out` and `adpcm_out` are 0.
- R2: A rising edge with `strobe`=1 and `busy`=0 captures the request. After that edge `busy`=1, `stage_hot`=6'b000001, and `cur_chan`, `cur_encode`, `cur_std726` and `cur_enh` show the captured inputs.
- R3: While `busy`=1 the strobe and all request inputs are ignored. The captured fields stay unchanged, and no second operation or flag change results.
- R4: `stage_hot` shifts left by one bit each clock, from bit 0 (stage 1) to bit 5 (stage 6). On the sixth rising edge after capture, `busy` falls and the result is written. A strobe on the very next edge is accepted.
- R5: An encode (`enc_sel`=1) pulls `enc_stat` to 0 on the capture edge and returns it to 1 on the result edge. `dec_stat` stays 1 throughout.
- R6: A decode (`enc_sel`=0) pulls `dec_stat` to 0 on the capture edge and returns it to 1 on the result edge. `enc_stat` stays 1 throughout.
- R7: `word_bits` 0, 1, 2, 3 select 2, 3, 4, 5-bit ADPCM words. Words sit in the MSBs of the 5-bit port: bits 4:3, 4:2, 4:1 or 4:0. Unused low bits of `adpcm_out` are 0, and unused low bits of `adpcm_in` are ignored.
- R8: Encode stub: `adpcm_out` becomes `pcm_in[13:9]` when `log_sel`=0, or `pcm_in[7:3]` when `log_sel`=1, masked to the word width.
- R9: Decode stub: the masked ADPCM word is placed in `pcm_out[13:9]` when `log_sel`=0, or in `pcm_out[7:3]` when `log_sel`=1. All other bits are 0.
- R10: The outputs are registered and hold between results. An encode never changes `pcm_out`, and a decode never changes `adpcm_out`.
- R11: Asserting `rst` in the middle of an operation aborts it at once and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| strobe | input | 1 | Request strobe |
| enc_sel | input | 1 | 1 encode, 0 decode |
| chan_in | input | 10 | Channel number of the request |
| log_sel | input | 1 | 1 logarithmic 8-bit PCM, 0 uniform PCM |
| std726_sel | input | 1 | Coding standard select, passed to datapath |
| enh_bits | input | 2 | Enhancement-bit count, passed to datapath |
| word_bits | input | 2 | ADPCM width code (0..3 → 2..5 bits) |
| pcm_in | input | 14 | PCM sample for encoding |
| adpcm_in | input | 5 | ADPCM word for decoding, MSB aligned |
| busy | output | 1 | Operation in progress |
| enc_stat | output | 1 | Encode status, 0 while an encode runs |
| dec_stat | output | 1 | Decode status, 0 while a decode runs |
| pcm_out | output | 14 | Registered decode result |
| adpcm_out | output | 5 | Registered encode result |
| stage_hot | output | 6 | One-hot stage index, bit 0 = stage 1 |
| cur_chan | output | 10 | Captured channel number |
| cur_encode | output | 1 | Captured direction |
| cur_std726 | output | 1 | Captured standard select |
| cur_enh | output | 2 | Captured enhancement-bit count |

## Verification
The bench builds the block with its default parameters: a 10-bit channel field, a 14-bit PCM word, a 5-bit ADPCM port and six stages. The 5-bit port makes all four width codes reachable, each with its own masking pattern. The 14-bit PCM word lets both the uniform field and the logarithmic field be exercised with distinct bit positions. With six stages, a stray strobe can be injected in the middle of an operation, back-to-back requests land on the first free edge, and a reset can fall inside a running schedule.

// File: rtl/chs_pkg.sv
package chs_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic       encode;
        logic       log_pcm;
        logic       std726;
        logic [1:0] enh;
        logic [1:0] wcode;
    } op_cfg_t;

endpackage

// File: rtl/chs_fsm.sv
module chs_fsm #(
    parameter int STAGES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    output logic              accept,
    output logic              finish,
    output logic              busy,
    output logic [STAGES-1:0] stage_hot
);
    import chs_pkg::*;

    localparam logic [STAGES-1:0] FIRST = {{(STAGES-1){1'b0}}, 1'b1};

    seq_state_t state_q, state_d;
    logic [STAGES-1:0] stage_q, stage_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            stage_q <= '0;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        stage_d = stage_q;
        accept  = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (strobe) begin           // ACCEPT
                    accept  = 1'b1;
                    state_d = SEQ_RUN;
                    stage_d = FIRST;
                end
            end
            SEQ_RUN: begin
                if (stage_q[STAGES-1]) begin // FINISH
                    finish  = 1'b1;
                    state_d = SEQ_IDLE;
                    stage_d = '0;
                end else begin               // ADVANCE
                    stage_d = stage_q << 1;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                stage_d = '0;
            end
        endcase
    end

    assign busy      = (state_q == SEQ_RUN);
    assign stage_hot = stage_q;

endmodule

// File: rtl/chs_capture.sv
module chs_capture #(
    parameter int CHAN_W = 10,
    parameter int PCM_W  = 14,
    parameter int ADP_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  chs_pkg::op_cfg_t  cfg_in,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic [PCM_W-1:0]  pcm_in,
    input  logic [ADP_W-1:0]  adpcm_in,
    output chs_pkg::op_cfg_t  cfg_q,
    output logic [CHAN_W-1:0] chan_q,
    output logic [PCM_W-1:0]  pcm_q,
    output logic [ADP_W-1:0]  adpcm_q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cfg_q   <= '0;
            chan_q  <= '0;
            pcm_q   <= '0;
            adpcm_q <= '0;
        end else if (accept) begin
            cfg_q   <= cfg_in;
            chan_q  <= chan_in;
            pcm_q   <= pcm_in;
            adpcm_q <= adpcm_in;
        end
    end
endmodule

// File: rtl/chs_result.sv
module chs_result #(
    parameter int PCM_W = 14,
    parameter int ADP_W = 5,
    parameter int LOG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             accept_enc,
    input  logic             finish,
    input  chs_pkg::op_cfg_t cfg_q,
    input  logic [PCM_W-1:0] pcm_q,
    input  logic [ADP_W-1:0] adpcm_q,
    output logic             enc_stat,
    output logic             dec_stat,
    output logic [PCM_W-1:0] pcm_out,
    output logic [ADP_W-1:0] adpcm_out
);
    localparam int MIN_W = ADP_W - 3;

    logic [ADP_W-1:0] mask;
    logic [ADP_W-1:0] enc_word;
    logic [PCM_W-1:0] dec_word;

    // MSB-aligned mask for the selected word width
    always_comb begin
        mask = '0;
        for (int i = 0; i < ADP_W; i++) begin
            if (i < (MIN_W + int'(cfg_q.wcode)))
                mask[ADP_W-1-i] = 1'b1;
        end
    end

    // pass-through stand-in for the transcoding datapath
    always_comb begin
        if (cfg_q.log_pcm)
            enc_word = pcm_q[LOG_W-1 -: ADP_W] & mask;
        else
            enc_word = pcm_q[PCM_W-1 -: ADP_W] & mask;
        dec_word = '0;
        if (cfg_q.log_pcm)
            dec_word[LOG_W-1 -: ADP_W] = adpcm_q & mask;
        else
            dec_word[PCM_W-1 -: ADP_W] = adpcm_q & mask;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            enc_stat  <= 1'b1;
            dec_stat  <= 1'b1;
            pcm_out   <= '0;
            adpcm_out <= '0;
        end else if (accept) begin
            if (accept_enc) enc_stat <= 1'b0;
            else            dec_stat <= 1'b0;
        end else if (finish) begin
            if (cfg_q.encode) begin
                adpcm_out <= enc_word;
                enc_stat  <= 1'b1;
            end else begin
                pcm_out   <= dec_word;
                dec_stat  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/chs_top.sv
module chs_top #(
    parameter int CHAN_W = 10,
    parameter int PCM_W  = 14,
    parameter int ADP_W  = 5,
    parameter int STAGES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              enc_sel,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic              log_sel,
    input  logic              std726_sel,
    input  logic [1:0]        enh_bits,
    input  logic [1:0]        word_bits,
    input  logic [PCM_W-1:0]  pcm_in,
    input  logic [ADP_W-1:0]  adpcm_in,
    output logic              busy,
    output logic              enc_stat,
    output logic              dec_stat,
    output logic [PCM_W-1:0]  pcm_out,
    output logic [ADP_W-1:0]  adpcm_out,
    output logic [STAGES-1:0] stage_hot,
    output logic [CHAN_W-1:0] cur_chan,
    output logic              cur_encode,
    output logic              cur_std726,
    output logic [1:0]        cur_enh
);
    import chs_pkg::*;

    logic             accept, finish;
    op_cfg_t          cfg_in, cfg_q;
    logic [PCM_W-1:0] pcm_q;
    logic [ADP_W-1:0] adpcm_q;

    assign cfg_in = '{encode: enc_sel, log_pcm: log_sel, std726: std726_sel,
                      enh: enh_bits, wcode: word_bits};

    chs_fsm #(.STAGES(STAGES)) u_fsm (
        .clk(clk), .rst(rst), .strobe(strobe),
        .accept(accept), .finish(finish), .busy(busy), .stage_hot(stage_hot)
    );

    chs_capture #(.CHAN_W(CHAN_W), .PCM_W(PCM_W), .ADP_W(ADP_W)) u_cap (
        .clk(clk), .rst(rst), .accept(accept), .cfg_in(cfg_in),
        .chan_in(chan_in), .pcm_in(pcm_in), .adpcm_in(adpcm_in),
        .cfg_q(cfg_q), .chan_q(cur_chan), .pcm_q(pcm_q), .adpcm_q(adpcm_q)
    );

    chs_result #(.PCM_W(PCM_W), .ADP_W(ADP_W)) u_res (
        .clk(clk), .rst(rst), .accept(accept), .accept_enc(enc_sel),
        .finish(finish), .cfg_q(cfg_q), .pcm_q(pcm_q), .adpcm_q(adpcm_q),
        .enc_stat(enc_stat), .dec_stat(dec_stat),
        .pcm_out(pcm_out), .adpcm_out(adpcm_out)
    );

    assign cur_encode = cfg_q.encode;
    assign cur_std726 = cfg_q.std726;
    assign cur_enh    = cfg_q.enh;

endmodule

// File: rtl/chs_checker.sv
module chs_checker #(
    parameter int CHAN_W = 10,
    parameter int PCM_W  = 14,
    parameter int ADP_W  = 5,
    parameter int STAGES = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe,
    input logic              busy,
    input logic              enc_stat,
    input logic              dec_stat,
    input logic [PCM_W-1:0]  pcm_out,
    input logic [ADP_W-1:0]  adpcm_out,
    input logic [STAGES-1:0] stage_hot,
    input logic [CHAN_W-1:0] cur_chan
);
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe && !busy) |=> (busy && stage_hot == {{(STAGES-1){1'b0}}, 1'b1}));

    p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur_chan));

    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage_hot) && (busy == (stage_hot != '0)));

    p_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !stage_hot[STAGES-1]) |=> (stage_hot == ($past(stage_hot) << 1)));

    p_finish_r4: assert property (@(posedge clk) disable iff (rst)
        stage_hot[STAGES-1] |=> (!busy && enc_stat && dec_stat));

    p_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (enc_stat || dec_stat) && (busy == (!enc_stat || !dec_stat)));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !stage_hot[STAGES-1]) |=> ($stable(pcm_out) && $stable(adpcm_out)));
endmodule

bind chs_top chs_checker #(.CHAN_W(CHAN_W), .PCM_W(PCM_W), .ADP_W(ADP_W), .STAGES(STAGES))
    u_chk (.*);

// File: tb/chs_top_test.sv
module chs_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        strobe, enc_sel, log_sel, std726_sel;
    logic [9:0]  chan_in;
    logic [1:0]  enh_bits, word_bits;
    logic [13:0] pcm_in;
    logic [4:0]  adpcm_in;
    logic        busy, enc_stat, dec_stat, cur_encode, cur_std726;
    logic [13:0] pcm_out;
    logic [4:0]  adpcm_out;
    logic [5:0]  stage_hot;
    logic [9:0]  cur_chan;
    logic [1:0]  cur_enh;

    int n_tests = 0;
    int n_fail  = 0;
    bit all_done = 0;
    logic [13:0] model_pcm = '0;
    logic [4:0]  model_adp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chs_top uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] wmask(input logic [1:0] w);
        return 5'b11111 << (3 - w);   // 2..5 bits from MSB (R7)
    endfunction

    function automatic logic [4:0] exp_enc(input logic lg, input logic [1:0] w, input logic [13:0] p);
        return (lg ? p[7:3] : p[13:9]) & wmask(w);  // R8
    endfunction

    function automatic logic [13:0] exp_dec(input logic lg, input logic [1:0] w, input logic [4:0] a);
        logic [4:0] m;
        m = a & wmask(w);
        return lg ? {6'b0, m, 3'b0} : {m, 9'b0};    // R9
    endfunction

    task automatic check_idle_outputs(input string tag);
        chk(busy == 0 && enc_stat && dec_stat && stage_hot == 0, tag,
            {busy, enc_stat, dec_stat, stage_hot}, {3'b011, 6'b0});
    endtask

    // one operation; optional stray strobe in mid schedule (R3)
    task automatic run_op(input logic e, input logic [9:0] ch, input logic lg,
                          input logic sd, input logic [1:0] en, input logic [1:0] w,
                          input logic [13:0] p, input logic [4:0] a, input bit stray);
        strobe = 1; enc_sel = e; chan_in = ch; log_sel = lg; std726_sel = sd;
        enh_bits = en; word_bits = w; pcm_in = p; adpcm_in = a;
        @(posedge clk); @(negedge clk);
        strobe = 0; chan_in = ~ch; enc_sel = ~e; pcm_in = ~p; adpcm_in = ~a;
        chk(busy && stage_hot == 6'b000001, "R2 capture", {busy, stage_hot}, 7'b1000001);
        chk(cur_chan == ch && cur_encode == e && cur_std726 == sd && cur_enh == en,
            "R2 fields", {cur_chan, cur_encode, cur_std726, cur_enh}, {ch, e, sd, en});
        if (e) chk(!enc_stat && dec_stat, "R5 flags low", {enc_stat, dec_stat}, 2'b01);
        else   chk(enc_stat && !dec_stat, "R6 flags low", {enc_stat, dec_stat}, 2'b10);
        for (int k = 1; k < 6; k++) begin
            if (stray && k == 2) strobe = 1;
            @(posedge clk); @(negedge clk);
            strobe = 0;
            chk(busy && stage_hot == (6'b1 << k), "R4 stage", stage_hot, 6'b1 << k);
            chk(pcm_out == model_pcm && adpcm_out == model_adp, "R10 hold",
                {pcm_out, adpcm_out}, {model_pcm, model_adp});
        end
        if (stray) chk(cur_chan == ch && cur_encode == e, "R3 stray ignored",
                       {cur_chan, cur_encode}, {ch, e});
        @(posedge clk); @(negedge clk);
        if (e) model_adp = exp_enc(lg, w, p);
        else   model_pcm = exp_dec(lg, w, a);
        check_idle_outputs("R4 finish");
        chk(adpcm_out == model_adp, e ? "R8 R7 encode" : "R10 adpcm kept", adpcm_out, model_adp);
        chk(pcm_out == model_pcm, e ? "R10 pcm kept" : "R9 R7 decode", pcm_out, model_pcm);
    endtask

    initial begin
        repeat (200000 - 10) @(posedge clk);
        if (!all_done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        strobe = 0; enc_sel = 0; chan_in = 0; log_sel = 0; std726_sel = 0;
        enh_bits = 0; word_bits = 0; pcm_in = 0; adpcm_in = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_idle_outputs("R1 reset");
        chk(pcm_out == 0 && adpcm_out == 0, "R1 outputs", {pcm_out, adpcm_out}, 0);

        // directed: every width, both PCM types, both directions
        for (int w = 0; w < 4; w++) begin
            run_op(1, 10'h3FF, 0, 1, 2'd3, 2'(w), 14'h3FFF, 5'h00, 0);
            run_op(0, 10'h000, 1, 0, 2'd1, 2'(w), 14'h0000, 5'h1F, 0);
        end
        run_op(1, 10'h155, 1, 0, 2'd2, 2'd3, 14'h00A8, 5'h00, 1);
        run_op(0, 10'h2AA, 0, 1, 2'd0, 2'd1, 14'h0000, 5'h17, 1);

        // constrained random
        for (int i = 0; i < 40; i++) begin
            run_op(1'($urandom), 10'($urandom), 1'($urandom), 1'($urandom),
                   2'($urandom), 2'($urandom), 14'($urandom), 5'($urandom),
                   ($urandom % 4) == 0);
        end

        // reset inside a running schedule (R11)
        strobe = 1; enc_sel = 1; word_bits = 3; pcm_in = 14'h3E00; log_sel = 0;
        @(posedge clk); @(negedge clk);
        strobe = 0;
        @(posedge clk); @(negedge clk);
        rst = 1;
        #1;
        check_idle_outputs("R11 abort");
        chk(pcm_out == 0 && adpcm_out == 0, "R11 outputs cleared", {pcm_out, adpcm_out}, 0);
        @(negedge clk);
        rst = 0;
        model_pcm = '0; model_adp = '0;
        repeat (7) @(negedge clk);
        check_idle_outputs("R11 stays idle");
        chk(adpcm_out == 0, "R11 no late result", adpcm_out, 0);

        all_done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule